// File: doc/BRIEF.md
# Windowed Transmit Level Controller

This block sets the attenuation of a transmitter output stage. The attenuation is a 3-bit code, and each step of the code is 3 dB more attenuation (code 0 is none, code 7 is the most). The block runs on the system clock and does work only on cycles where a chip-rate enable is high. A level detector outside the block supplies two flags. One says the sensed output is above the target and the other says it is below.

The block adapts the code only for a short window of chip periods. The window opens after a hard reset, after a soft reset pulse, and when the transmit enable rises. When the window opens, the code is seeded from a programmed level. Each update takes two chip periods. In the first, the detector flags are captured. In the second, the code moves one step in the indicated direction. When the window closes, the code is held until the next opening.

A bypass bit overrides the adaptive loop. While it is set, the output equals the programmed level at once.

Top module: `tx_level_ctrl`

## Requirements
- R1: After the hard reset is released, the first clock edge loads the code from `cfg_level` and opens the window. While reset is held, `atten` is 0 unless bypass is set.
- R2: Chip ticks inside the window alternate between evaluate and adjust, starting with evaluate. An evaluate tick captures `lvl_hi`/`lvl_lo` and leaves the code unchanged. An adjust tick changes the code using the captured flags, not the flags present at the adjust tick, and the new code appears on `atten` right after that tick's clock edge.
- R3: `win_open` is high from the window start for exactly 16 chip ticks and is low after the 16th tick.
- R4: A one-cycle `soft_rst` pulse, or a 0-to-1 change of `tx_en`, reloads the code from `cfg_level` and reopens the window with an evaluate tick first. Holding `tx_en` high or lowering it does neither.
- R5: At an adjust tick, captured above-only adds 1 to the code, below-only subtracts 1, and neither-or-both leaves it unchanged.
- R6: The code saturates at 0 and at 7 and never wraps.
- R7: While the window is closed, the code does not change whatever the flags and chip ticks do.
- R8: While `cfg_bypass` is 1, `atten` equals `cfg_level` in the same cycle. The adaptive code is reloaded from `cfg_level` on each edge, so clearing bypass resumes adaptation from that level. Window counting continues during bypass.
- R9: Clock cycles with `chip_en` low change neither the code nor the window, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse, restarts the window |
| tx_en | input | 1 | Transmit mode; a rising edge restarts the window |
| chip_en | input | 1 | Chip-rate clock enable |
| lvl_hi | input | 1 | Sensed level above target |
| lvl_lo | input | 1 | Sensed level below target |
| cfg_bypass | input | 1 | Use the programmed level instead of the loop |
| cfg_level | input | 3 | Programmed level and seed for the loop |
| atten | output | 3 | Attenuation code, 3 dB per step |
| win_open | output | 1 | High while adaptation is allowed |

## Verification
The bench sweeps every seed level against every flag combination through a full window. On adjust ticks it drives flags that are the opposite of the ones given at evaluate. A design that adjusted from the live flags, or moved on evaluate ticks, therefore drifts the wrong way. Runs seeded at 0 and at 7 that push outward catch a code that wraps. Extra ticks after the 16th catch a window that is one tick off or a code that keeps adapting. Restart tests with a held or falling `tx_en` catch level-triggered restarts. The bypass test checks that the output is forced in the same cycle and that adaptation resumes from the programmed level, not from the stale code.

// File: rtl/tx_level_ctrl.sv
module tx_level_ctrl #(
  parameter int CODE_W    = 3,
  parameter int WIN_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              tx_en,
  input  logic              chip_en,
  input  logic              lvl_hi,
  input  logic              lvl_lo,
  input  logic              cfg_bypass,
  input  logic [CODE_W-1:0] cfg_level,
  output logic [CODE_W-1:0] atten,
  output logic              win_open
);
  localparam int CNT_W = $clog2(WIN_TICKS + 1);
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(WIN_TICKS);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic              tx_q, armed_q, adj_q, hi_q, lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;

  logic start, tick, go_up, go_dn;

  assign start    = !armed_q | soft_rst | (tx_en & !tx_q);
  assign win_open = (cnt_q != CNT_END);
  assign tick     = chip_en & win_open & !start;
  assign go_up    = hi_q & !lo_q & (code_q != CODE_MAX);
  assign go_dn    = lo_q & !hi_q & (code_q != '0);
  assign atten    = cfg_bypass ? cfg_level : code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      adj_q   <= 1'b0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      tx_q    <= tx_en;
      armed_q <= 1'b1;
      if (start) begin
        cnt_q <= '0;
        adj_q <= 1'b0;
        hi_q  <= 1'b0;
        lo_q  <= 1'b0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
        adj_q <= !adj_q;
        if (!adj_q) begin
          hi_q <= lvl_hi;
          lo_q <= lvl_lo;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code_q <= '0;
    else if (start || cfg_bypass)
      code_q <= cfg_level;
    else if (tick && adj_q)
      code_q <= code_q + CODE_W'(go_up) - CODE_W'(go_dn);
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (code_q == $past(cfg_level)));

  assert_eval_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !adj_q && !cfg_bypass) |=> (code_q == $past(code_q)));

  assert_win_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cfg_bypass) |=> (code_q == $past(code_q) ||
                                 code_q == $past(code_q) + 1'b1 ||
                                 code_q == $past(code_q) - 1'b1));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cfg_bypass && code_q == CODE_MAX) |=> (code_q != '0));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cfg_bypass && !win_open) |=> (code_q == $past(code_q)));
endmodule

// File: tb/sim_tx_level_ctrl.sv
module sim_tx_level_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, tx_en = 1'b0, chip_en = 1'b0;
  logic lvl_hi = 1'b0, lvl_lo = 1'b0, cfg_bypass = 1'b0;
  logic [2:0] cfg_level = 3'd3;
  logic [2:0] atten;
  logic win_open;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_cnt, m_code;
  bit m_adj, m_hi, m_lo;

  tx_level_ctrl u0 (.clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en),
    .chip_en(chip_en), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo), .cfg_bypass(cfg_bypass),
    .cfg_level(cfg_level), .atten(atten), .win_open(win_open));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk({req, " atten"}, atten, cfg_bypass ? cfg_level : m_code);
    chk({req, " win_open"}, win_open, m_cnt < 16);
  endtask

  task automatic model_start();
    m_cnt = 0; m_adj = 0; m_hi = 0; m_lo = 0; m_code = cfg_level;
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tick(input bit h, input bit l, input string req);
    lvl_hi = h; lvl_lo = l; chip_en = 1'b1;
    cyc();
    chip_en = 1'b0;
    if (m_cnt < 16) begin
      if (!m_adj) begin m_hi = h; m_lo = l; end
      else if (m_hi && !m_lo && m_code < 7) m_code++;
      else if (m_lo && !m_hi && m_code > 0) m_code--;
      m_adj = !m_adj; m_cnt++;
    end
    if (cfg_bypass) m_code = cfg_level;
    chk_out(req);
    lvl_hi = !h; lvl_lo = 1'b1;
    cyc();
    chk_out("R9 idle");
  endtask

  task automatic soft_restart();
    soft_rst = 1'b1; cyc(); soft_rst = 1'b0;
    model_start();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_code = 0; m_cnt = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 atten in reset", atten, 0);
    rst_n = 1'b1;
    cyc();
    model_start();
    chk_out("R1 after reset");

    // R5 R6 R2: every seed with every flag pattern, opposite flags on adjust ticks
    for (int lv = 0; lv < 8; lv++) begin
      for (int pat = 0; pat < 4; pat++) begin
        cfg_level = 3'(lv);
        soft_restart();
        chk_out("R4 soft restart");
        for (int k = 0; k < 16; k++) begin
          if (k % 2 == 0) tick(pat[0], pat[1], "R2 R5 eval/adjust");
          else            tick(!pat[0], !pat[1], "R2 adjust uses captured flags");
        end
        begin
          int fin;
          fin = lv;
          if (pat == 1) fin = (lv + 8 > 7) ? 7 : lv + 8;
          if (pat == 2) fin = (lv - 8 < 0) ? 0 : lv - 8;
          chk("R6 R5 final code", atten, fin);
        end
        chk("R3 window closed", win_open, 0);
        for (int k = 0; k < 4; k++) tick(k[0], !k[0], "R7 frozen");
      end
    end

    // R4: transmit entry edge only
    cfg_level = 3'd2;
    tx_en = 1'b1; cyc(); model_start();
    chip_en = 1'b0;
    chk_out("R4 tx rise");
    tick(1, 0, "R4 after tx rise"); tick(0, 0, "R4 after tx rise");
    chk("R4 step after tx rise", atten, 3);
    for (int k = 0; k < 20; k++) tick(1, 0, "R4 tx held");
    chk("R4 no retrigger held", win_open, 0);
    tx_en = 1'b0; cyc();
    chk_out("R4 tx fall no restart");

    // R8: bypass in the window
    cfg_level = 3'd1;
    soft_restart();
    tick(1, 0, "R8 pre"); tick(1, 0, "R8 pre");
    cfg_level = 3'd5; cfg_bypass = 1'b1; #1;
    chk("R8 immediate force", atten, 5);
    @(negedge clk);
    m_code = 5;
    tick(0, 1, "R8 bypassed eval"); tick(0, 1, "R8 bypassed adjust");
    cfg_bypass = 1'b0; #1;
    chk("R8 resume from level", atten, 5);
    @(negedge clk);
    tick(0, 1, "R8 resumed"); tick(1, 1, "R8 resumed");
    chk("R8 adapts from level", atten, 4);
    chk("R8 window kept counting", win_open, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule